// File: doc/BRIEF.md
# Step-Down Converter Light-Load Mode Controller

This block is the digital mode controller for a single step-down converter channel. It decides on every PWM period whether the high-side switch is driven by the fixed-frequency duty loop or by a pulse-skipping burst sequencer. The switch-node sensor reports whether the inductor current reached zero during a period. Once that has happened for a set run of back-to-back periods and automatic mode is selected, the controller leaves PWM and starts the burst sequence.

In the burst sequence every pulse starts on a PWM period boundary and ends when the switch current reaches the light-load current threshold. Pulsing pauses while the output sits above its upper band edge and restarts once the output falls below nominal. A drop below the lower band edge returns the channel to PWM. The peak-current flag cuts the gate request in every mode without waiting for a clock. The zero-cross flag and the three output comparator flags pass through a two-flop synchronizer before the controller uses them.

Top module: `skip_mode_ctrl`

## Requirements
- R1: With `modeAuto`=1, `skipMode` goes high on the PWM boundary (`pwmTick` edge) that closes the 16th consecutive period in which `zeroCross` was seen, and not earlier.
- R2: A period closed without a zero crossing clears the run count, so a further 16 full zero-cross periods are needed before skip mode is entered.
- R3: In skip mode with pulsing active, `gateReq` rises at the `pwmTick` edge and is never set between boundaries.
- R4: A skip pulse ends when `curSkipLvl` is high: `gateReq` drops in that same cycle and stays low until the next boundary, even after `curSkipLvl` falls.
- R5: While the synchronized `outOverHi` is high in skip mode, `gateReq` is low. Pulsing then stays stopped on later boundaries, including after `outOverHi` falls, for as long as `outAtNom` stays high.
- R6: After pulsing has stopped, a low `outAtNom` (output below nominal) restarts pulsing, and the next boundary produces a pulse.
- R7: A high synchronized `outUnderLo` in skip mode returns the controller to PWM (`skipMode`=0) on the next edge, and the run count restarts from zero.
- R8: With `modeAuto`=0 (forced PWM) skip mode is never entered, however many zero-cross periods occur. Clearing `modeAuto` while in skip mode returns to PWM on the next clock edge.
- R9: `curPeakLim`=1 forces `gateReq` low in the same cycle in every mode.
- R10: In PWM mode `gateReq` follows `pwmGate`.
- R11: `zeroCross`, `outOverHi`, `outAtNom` and `outUnderLo` act only after two clock edges of synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, many cycles per PWM period |
| rstN | input | 1 | Active-low synchronous reset |
| pwmTick | input | 1 | One-cycle strobe marking the PWM period boundary |
| modeAuto | input | 1 | 1 = automatic skip/PWM, 0 = forced PWM |
| zeroCross | input | 1 | Inductor current zero-cross flag (asynchronous) |
| outOverHi | input | 1 | Output above nominal +1.5 % (asynchronous) |
| outAtNom | input | 1 | Output at or above nominal (asynchronous) |
| outUnderLo | input | 1 | Output below nominal -1.5 % (asynchronous) |
| curSkipLvl | input | 1 | Switch current at the light-load threshold (20 % of peak limit) |
| curPeakLim | input | 1 | Switch current at the peak limit |
| pwmGate | input | 1 | Gate request from the PWM duty loop |
| gateReq | output | 1 | High-side switch gate request |
| skipMode | output | 1 | 1 while the channel is in skip mode |

## Verification
Every cycle, the assertions check that the peak limit keeps the gate low, that an over-band output holds the gate off in skip mode, that skip pulses start only on a boundary, and that forced mode and an under-band output leave skip mode. They also check that the run count stays within its limit. Only the bench scenarios can show the exact period on which skip mode is entered, that the count restarts after a missed period, and which comparator changes make the stop-and-resume sequence advance. The bench sweeps every position of a missed period within the run and checks the entry boundary each time.

// File: rtl/skipctl_pkg.sv
package skipctl_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClear;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic entryReady;
    logic overHi;
    logic atNom;
    logic underLo;
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_PWM   = 2'd0,
    ST_BURST = 2'd1,
    ST_HOLD  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/skipctl_datapath.sv
module skipctl_datapath
  import skipctl_pkg::*;
#(
  parameter int ENTRY_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmTick,
  input  logic       zeroCross,
  input  logic       overHi,
  input  logic       atNom,
  input  logic       underLo,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int CW    = $clog2(ENTRY_CYCLES + 1);
  localparam int NFLAG = 4;
  localparam logic [CW-1:0] CNT_MAX  = CW'(ENTRY_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(ENTRY_CYCLES - 1);

  logic [NFLAG-1:0] rawFlags;
  logic [NFLAG-1:0] syncStage [SYNC_STAGES];
  logic [NFLAG-1:0] syncFlags;
  logic             zcSeen;
  logic             cycleZc;
  logic [CW-1:0]    runCnt;

  assign rawFlags = {underLo, atNom, overHi, zeroCross};

  // synchronizer chain for the asynchronous sensor flags (R11)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= '0;
    end else begin
      syncStage[0] <= rawFlags;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
    end
  end

  assign syncFlags = syncStage[SYNC_STAGES-1];

  // sticky zero-cross seen within the current PWM period
  always_ff @(posedge clk) begin
    if (!rstN)          zcSeen <= 1'b0;
    else if (pwmTick)   zcSeen <= 1'b0;
    else if (syncFlags[0]) zcSeen <= 1'b1;
  end

  assign cycleZc = zcSeen | syncFlags[0];

  // consecutive zero-cross period counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                 runCnt <= '0;
    else if (strobe.cntClear)  runCnt <= '0;
    else if (pwmTick) begin
      if (!cycleZc)                runCnt <= '0;
      else if (runCnt != CNT_MAX)  runCnt <= runCnt + 1'b1;
    end
  end

  assign status.entryReady = pwmTick & cycleZc & ~strobe.cntClear & (runCnt >= CNT_LAST);
  assign status.overHi     = syncFlags[1];
  assign status.atNom      = syncFlags[2];
  assign status.underLo    = syncFlags[3];

  a_r2_cnt_saturates: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= CNT_MAX);

  a_r2_cnt_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> runCnt == '0);

endmodule

// File: rtl/skipctl_control.sv
module skipctl_control
  import skipctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmTick,
  input  logic       modeAuto,
  input  logic       curSkipLvl,
  input  logic       curPeakLim,
  input  logic       pwmGate,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       gateReq,
  output logic       skipMode
);
  ctlState_t state, stateN;
  logic      gateLatch, gateLatchN;

  always_comb begin
    stateN = state;
    unique case (state)
      ST_PWM: begin
        if (modeAuto && status.entryReady) stateN = ST_BURST;
      end
      ST_BURST, ST_HOLD: begin
        if (!modeAuto || status.underLo)            stateN = ST_PWM;
        else if (status.overHi)                     stateN = ST_HOLD;
        else if (state == ST_HOLD && !status.atNom) stateN = ST_BURST;
      end
      default: stateN = ST_PWM;
    endcase
  end

  always_comb begin
    gateLatchN = 1'b0;
    if (state == ST_BURST && stateN == ST_BURST) begin
      if (pwmTick && !curPeakLim)         gateLatchN = 1'b1;
      else if (curSkipLvl || curPeakLim)  gateLatchN = 1'b0;
      else                                gateLatchN = gateLatch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_PWM;
      gateLatch <= 1'b0;
    end else begin
      state     <= stateN;
      gateLatch <= gateLatchN;
    end
  end

  assign strobe.cntClear = (state != ST_PWM) | ~modeAuto;
  assign skipMode        = (state != ST_PWM);

  always_comb begin
    unique case (state)
      ST_PWM:   gateReq = pwmGate & ~curPeakLim;
      ST_BURST: gateReq = gateLatch & ~curSkipLvl & ~curPeakLim & ~status.overHi;
      default:  gateReq = 1'b0;
    endcase
  end

  a_r9_peak_blocks_gate: assert property (@(posedge clk) disable iff (!rstN)
    curPeakLim |-> !gateReq);

  a_r5_over_blocks_gate: assert property (@(posedge clk) disable iff (!rstN)
    (skipMode && status.overHi) |-> !gateReq);

  a_r3_pulse_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateLatch) |-> $past(pwmTick));

  a_r8_forced_leaves_skip: assert property (@(posedge clk) disable iff (!rstN)
    !modeAuto |=> !skipMode);

  a_r7_under_exits: assert property (@(posedge clk) disable iff (!rstN)
    (skipMode && status.underLo) |=> !skipMode);

  a_r1_entry_needs_auto: assert property (@(posedge clk) disable iff (!rstN)
    $rose(skipMode) |-> $past(modeAuto));

endmodule

// File: rtl/skip_mode_ctrl.sv
module skip_mode_ctrl
  import skipctl_pkg::*;
#(
  parameter int ENTRY_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmTick,
  input  logic modeAuto,
  input  logic zeroCross,
  input  logic outOverHi,
  input  logic outAtNom,
  input  logic outUnderLo,
  input  logic curSkipLvl,
  input  logic curPeakLim,
  input  logic pwmGate,
  output logic gateReq,
  output logic skipMode
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  skipctl_datapath #(
    .ENTRY_CYCLES(ENTRY_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .pwmTick   (pwmTick),
    .zeroCross (zeroCross),
    .overHi    (outOverHi),
    .atNom     (outAtNom),
    .underLo   (outUnderLo),
    .strobe    (strobe),
    .status    (status)
  );

  skipctl_control uControl (
    .clk        (clk),
    .rstN       (rstN),
    .pwmTick    (pwmTick),
    .modeAuto   (modeAuto),
    .curSkipLvl (curSkipLvl),
    .curPeakLim (curPeakLim),
    .pwmGate    (pwmGate),
    .status     (status),
    .strobe     (strobe),
    .gateReq    (gateReq),
    .skipMode   (skipMode)
  );

endmodule

// File: tb/tb_skip_mode_ctrl.sv
module tb_skip_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRY      = 16;
  localparam int PERIOD_CLK = 8;

  logic clk = 1'b0;
  logic rstN, pwmTick, modeAuto, zeroCross, outOverHi, outAtNom, outUnderLo;
  logic curSkipLvl, curPeakLim, pwmGate;
  logic gateReq, skipMode;
  int   errors = 0;
  int   checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .pwmTick(pwmTick), .modeAuto(modeAuto),
    .zeroCross(zeroCross), .outOverHi(outOverHi), .outAtNom(outAtNom),
    .outUnderLo(outUnderLo), .curSkipLvl(curSkipLvl), .curPeakLim(curPeakLim),
    .pwmGate(pwmGate), .gateReq(gateReq), .skipMode(skipMode)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pwmTick = 1'b0; modeAuto = 1'b1; zeroCross = 1'b0;
    outOverHi = 1'b0; outAtNom = 1'b0; outUnderLo = 1'b0;
    curSkipLvl = 1'b0; curPeakLim = 1'b0; pwmGate = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one PWM period; returns at the negedge right after the boundary edge
  task automatic runPeriod(input logic zc);
    for (int i = 0; i < PERIOD_CLK; i++) begin
      @(negedge clk);
      zeroCross = zc && (i == 1);
      pwmTick   = (i == PERIOD_CLK - 1);
    end
    @(negedge clk);
    pwmTick   = 1'b0;
    zeroCross = 1'b0;
  endtask

  task automatic enterSkip();
    for (int n = 0; n < ENTRY; n++) runPeriod(1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    check("R10 reset skipMode", skipMode, 1'b0);
    check("R10 reset gateReq", gateReq, 1'b0);

    // R1: entry on exactly the 16th zero-cross period
    for (int n = 0; n < ENTRY - 1; n++) runPeriod(1'b1);
    check("R1 no entry after 15", skipMode, 1'b0);
    runPeriod(1'b1);
    check("R1 entry at 16", skipMode, 1'b1);

    // R2: sweep position of a missed period
    for (int k = 0; k < ENTRY; k++) begin
      doReset();
      for (int n = 0; n < k; n++) runPeriod(1'b1);
      runPeriod(1'b0);
      check("R2 no entry after miss", skipMode, 1'b0);
      for (int n = 0; n < ENTRY - 1; n++) runPeriod(1'b1);
      check("R2 still out at 15 fresh", skipMode, 1'b0);
      runPeriod(1'b1);
      check("R2 entry at 16 fresh", skipMode, 1'b1);
    end

    // R11: a zero crossing held for only one clock right before the boundary is too late
    doReset();
    for (int n = 0; n < ENTRY - 1; n++) runPeriod(1'b1);
    for (int i = 0; i < PERIOD_CLK; i++) begin
      @(negedge clk);
      zeroCross = (i == PERIOD_CLK - 1);
      pwmTick   = (i == PERIOD_CLK - 1);
    end
    @(negedge clk);
    pwmTick = 1'b0; zeroCross = 1'b0;
    check("R11 late zero-cross not counted", skipMode, 1'b0);

    // R3/R4: pulses in skip mode
    doReset();
    enterSkip();
    check("R3 no pulse on entry boundary", gateReq, 1'b0);
    runPeriod(1'b0);
    check("R3 pulse at boundary", gateReq, 1'b1);
    @(negedge clk);
    check("R3 pulse held", gateReq, 1'b1);
    curSkipLvl = 1'b1; #1;
    check("R4 pulse cut same cycle", gateReq, 1'b0);
    @(negedge clk);
    curSkipLvl = 1'b0; #1;
    check("R4 stays off after release", gateReq, 1'b0);
    runPeriod(1'b0);
    check("R3 next pulse", gateReq, 1'b1);

    // R9 in skip
    curPeakLim = 1'b1; #1;
    check("R9 peak cuts skip pulse", gateReq, 1'b0);
    @(negedge clk); curPeakLim = 1'b0; #1;
    check("R9 stays off", gateReq, 1'b0);

    // R5: over band stops pulsing
    runPeriod(1'b0);
    check("R5 pulse before over", gateReq, 1'b1);
    outOverHi = 1'b1; outAtNom = 1'b1;
    @(negedge clk);
    check("R11 over not yet seen", gateReq, 1'b1);
    repeat (2) @(negedge clk);
    check("R5 gate off on over", gateReq, 1'b0);
    runPeriod(1'b0);
    check("R5 no pulse while over", gateReq, 1'b0);
    outOverHi = 1'b0;
    runPeriod(1'b0);
    check("R5 no pulse at nominal", gateReq, 1'b0);
    check("R5 still skip", skipMode, 1'b1);

    // R6: resume below nominal
    outAtNom = 1'b0;
    runPeriod(1'b0);
    check("R6 resume pulse", gateReq, 1'b1);

    // R7: under band exits
    outUnderLo = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 exit to PWM", skipMode, 1'b0);
    outUnderLo = 1'b0;
    pwmGate = 1'b1; #1;
    check("R10 follows duty high", gateReq, 1'b1);
    curPeakLim = 1'b1; #1;
    check("R9 peak in PWM", gateReq, 1'b0);
    curPeakLim = 1'b0; pwmGate = 1'b0; #1;
    check("R10 follows duty low", gateReq, 1'b0);
    for (int n = 0; n < ENTRY - 1; n++) runPeriod(1'b1);
    check("R7 count restarted", skipMode, 1'b0);
    runPeriod(1'b1);
    check("R7 reenter after 16", skipMode, 1'b1);

    // R8: forced PWM
    doReset();
    modeAuto = 1'b0;
    for (int n = 0; n < 2 * ENTRY + 4; n++) runPeriod(1'b1);
    check("R8 forced never skips", skipMode, 1'b0);
    modeAuto = 1'b1;
    enterSkip();
    check("R8 auto enters", skipMode, 1'b1);
    runPeriod(1'b0);
    modeAuto = 1'b0;
    @(negedge clk);
    check("R8 mid-burst exit next edge", skipMode, 1'b0);
    pwmGate = 1'b1; #1;
    check("R10 forced follows duty", gateReq, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule